// File: doc/BRIEF.md
# NAND Flash Check-Code Compare and Single-Bit Corrector

This block compares the 3-byte check code stored with a 512-byte flash sector against the 3-byte code recomputed from the data just read. On a `start` strobe it captures both codes. It regroups each code into a fixed 24-bit order and XORs the two into a difference word. From that word it decides whether the sector is clean, holds one flipped data bit that can be repaired, holds one flipped bit inside the stored code only, or is beyond repair.

For a repairable error the block reports the byte offset inside the sector (0 to 511) and the bit number inside that byte (0 to 7). A data byte can be supplied with the strobe. The block returns that byte with the faulty bit inverted when the result is a data-bit repair, and returns it unchanged in every other case. The result is registered and is presented one cycle after the strobe, together with a one-cycle valid pulse. A new strobe may arrive on every cycle.

Top module: `ecc_pair_corrector`

## Requirements
- R1: While reset is held, and after it until the first strobe, `valid`, `status`, `byte_addr`, `bit_idx` and `data_out` are all zero.
- R2: `valid` is high in exactly the cycle after each cycle with `start` high. The outputs update only at the edges where `start` is high, and hold their values otherwise. Strobes on consecutive cycles each yield their own result.
- R3: When `ecc_read` equals `ecc_calc`, status is 2'b00 (clean).
- R4: Each input code carries byte e0 in bits [7:0], e1 in [15:8] and e2 in [23:16]. Each code is regrouped into O = {e2[1:0], e1, e0, e2[7:2]}, with bit 23 as the MSB. The difference word D is the XOR of the two regrouped codes.
- R5: When every bit pair (D[2k+1], D[2k]) for k = 0..11 has at least one bit set, status is 2'b01 (data bit repaired).
- R6: When exactly one bit of D is set, status is 2'b10 (error in the stored code only).
- R7: Any other nonzero D gives status 2'b11 (uncorrectable).
- R8: With status 2'b01, bit k of `bit_idx` equals D[2k+1] for k = 0..2, and bit k of `byte_addr` equals D[7+2k] for k = 0..8. With any other status, both outputs are zero.
- R9: `data_out` equals the `data_in` captured with the strobe, XOR (1 << `bit_idx`) when the status is 2'b01. With any other status it equals the captured `data_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture and evaluate the codes on this edge |
| ecc_read | input | 24 | Check code read from flash, e2:e1:e0 |
| ecc_calc | input | 24 | Check code recomputed from the data, e2:e1:e0 |
| data_in | input | 8 | Data byte to be repaired if needed |
| valid | output | 1 | One-cycle pulse marking a fresh result |
| status | output | 2 | 00 clean, 01 repaired, 10 code-only, 11 uncorrectable |
| byte_addr | output | 9 | Offset of the faulty byte |
| bit_idx | output | 3 | Faulty bit inside that byte |
| data_out | output | 8 | Data byte after the optional repair |

## Verification
Two functions can act in the same cycle. One is the registered repair of a data byte from a strobe. The other is the capture of a new strobe, which replaces that result while it is still being read. The bench provokes this with a run of strobes on consecutive cycles that mix repair, code-only, clean and uncorrectable cases. At each falling edge it first checks the status, the indices and the flipped byte of the previous strobe, and only then drives the next one. This shows that no result leaks into its neighbour. The expected values come from error patterns that the bench builds to land on a chosen byte and bit, and from a reference classifier for random code pairs.

// File: rtl/ecc_cmp_pkg.sv
package ecc_cmp_pkg;
   typedef enum logic [1:0] {
      ST_CLEAN     = 2'b00,
      ST_FIXED     = 2'b01,
      ST_CODE_ONLY = 2'b10,
      ST_FATAL     = 2'b11
   } ecc_status_e;
endpackage

// File: rtl/ecc_code_order.sv
module ecc_code_order #(
   parameter int CODE_W = 24,
   parameter int BYTE_W = 8,
   parameter int TAIL_W = 2
) (
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_ord
);
   localparam int LOW_W = CODE_W - BYTE_W;

   generate
      if (TAIL_W < 1 || TAIL_W >= BYTE_W) begin : g_bad_tail
         $error("ecc_code_order: TAIL_W out of range");
      end
   endgenerate

   // top byte is split: its low TAIL_W bits go to the top, the rest to the bottom
   assign code_ord = {code_in[LOW_W +: TAIL_W],
                      code_in[LOW_W-1:0],
                      code_in[CODE_W-1 -: (BYTE_W-TAIL_W)]};
endmodule

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify
   import ecc_cmp_pkg::*;
#(
   parameter int CODE_W = 24,
   parameter int ADDR_W = 9,
   parameter int BIT_W  = 3
) (
   input  logic [CODE_W-1:0] diff,
   output ecc_status_e       status,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [BIT_W-1:0]  bit_idx
);
   localparam int NPAIR = CODE_W / 2;
   localparam logic [CODE_W-1:0] ONE = {{(CODE_W-1){1'b0}}, 1'b1};

   logic [NPAIR-1:0] pair_hit;
   logic [NPAIR-1:0] odd_bits;
   logic             all_pairs;
   logic             single;

   generate
      if (NPAIR != ADDR_W + BIT_W || (CODE_W % 2) != 0) begin : g_bad_geom
         $error("ecc_syndrome_classify: code width does not match index widths");
      end
      for (genvar k = 0; k < NPAIR; k++) begin : g_pair
         assign pair_hit[k] = diff[2*k] | diff[2*k+1];
         assign odd_bits[k] = diff[2*k+1];
      end
   endgenerate

   assign all_pairs = &pair_hit;
   assign single    = (diff != '0) && ((diff & (diff - ONE)) == '0);

   always_comb begin
      status    = ST_FATAL;
      byte_addr = '0;
      bit_idx   = '0;
      if (diff == '0) begin
         status = ST_CLEAN;
      end else if (all_pairs) begin
         status    = ST_FIXED;
         bit_idx   = odd_bits[BIT_W-1:0];
         byte_addr = odd_bits[NPAIR-1:BIT_W];
      end else if (single) begin
         status = ST_CODE_ONLY;
      end
   end
endmodule

// File: rtl/ecc_bit_flip.sv
module ecc_bit_flip #(
   parameter int DATA_W    = 8,
   parameter int BIT_W     = 3,
   parameter bit APPLY_FIX = 1'b1
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [BIT_W-1:0]  bit_idx,
   input  logic              flip_en,
   output logic [DATA_W-1:0] data_out
);
   generate
      if (DATA_W != (1 << BIT_W)) begin : g_bad_width
         $error("ecc_bit_flip: DATA_W must equal 2**BIT_W");
      end
      if (APPLY_FIX) begin : g_flip
         logic [DATA_W-1:0] mask;
         always_comb begin
            mask = '0;
            mask[bit_idx] = flip_en;
         end
         assign data_out = data_in ^ mask;
      end else begin : g_pass
         logic unused_ok;
         assign unused_ok = flip_en ^ (^bit_idx);
         assign data_out  = data_in;
      end
   endgenerate
endmodule

// File: rtl/ecc_pair_corrector.sv
module ecc_pair_corrector
   import ecc_cmp_pkg::*;
#(
   parameter int CODE_W    = 24,
   parameter int BYTE_W    = 8,
   parameter int TAIL_W    = 2,
   parameter int ADDR_W    = 9,
   parameter int BIT_W     = 3,
   parameter int DATA_W    = 8,
   parameter bit APPLY_FIX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [23:0]       ecc_read,
   input  logic [23:0]       ecc_calc,
   input  logic [7:0]        data_in,
   output logic              valid,
   output logic [1:0]        status,
   output logic [8:0]        byte_addr,
   output logic [2:0]        bit_idx,
   output logic [7:0]        data_out
);
   generate
      if (CODE_W != 24 || ADDR_W != 9 || BIT_W != 3 || DATA_W != 8) begin : g_bad_ports
         $error("ecc_pair_corrector: port widths are fixed by the sector geometry");
      end
   endgenerate

   logic [CODE_W-1:0] read_ord, calc_ord, diff;
   ecc_status_e       st_c;
   logic [ADDR_W-1:0] addr_c;
   logic [BIT_W-1:0]  bit_c;
   logic [DATA_W-1:0] dout_c;

   ecc_code_order #(.CODE_W(CODE_W), .BYTE_W(BYTE_W), .TAIL_W(TAIL_W)) u_ord_rd (
      .code_in(ecc_read), .code_ord(read_ord));
   ecc_code_order #(.CODE_W(CODE_W), .BYTE_W(BYTE_W), .TAIL_W(TAIL_W)) u_ord_cc (
      .code_in(ecc_calc), .code_ord(calc_ord));

   assign diff = read_ord ^ calc_ord;

   ecc_syndrome_classify #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_cls (
      .diff(diff), .status(st_c), .byte_addr(addr_c), .bit_idx(bit_c));

   ecc_bit_flip #(.DATA_W(DATA_W), .BIT_W(BIT_W), .APPLY_FIX(APPLY_FIX)) u_flip (
      .data_in(data_in), .bit_idx(bit_c), .flip_en(st_c == ST_FIXED), .data_out(dout_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid     <= 1'b0;
         status    <= 2'b00;
         byte_addr <= '0;
         bit_idx   <= '0;
         data_out  <= '0;
      end else begin
         valid <= start;
         if (start) begin
            status    <= st_c;
            byte_addr <= addr_c;
            bit_idx   <= bit_c;
            data_out  <= dout_c;
         end
      end
   end

   assert_valid_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> valid);
   assert_valid_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(start));
   assert_hold_without_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(status) && $stable(data_out) && $stable(byte_addr)));
   assert_clean_means_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && status == 2'b00) |-> ($past(ecc_read) == $past(ecc_calc)));
   assert_index_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && status != 2'b01) |-> (byte_addr == '0 && bit_idx == '0));

   generate
      if (APPLY_FIX) begin : g_flip_chk
         assert_single_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && status == 2'b01) |-> ($countones(data_out ^ $past(data_in)) == 1));
         assert_no_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && status != 2'b01) |-> (data_out == $past(data_in)));
      end
   endgenerate
endmodule

// File: tb/ecc_pair_corrector_tb.sv
module ecc_pair_corrector_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [23:0] ecc_read = '0, ecc_calc = '0;
   logic [7:0]  data_in = '0;
   logic        valid;
   logic [1:0]  status;
   logic [8:0]  byte_addr;
   logic [2:0]  bit_idx;
   logic [7:0]  data_out;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   ecc_pair_corrector u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ecc_read(ecc_read), .ecc_calc(ecc_calc),
      .data_in(data_in), .valid(valid), .status(status), .byte_addr(byte_addr),
      .bit_idx(bit_idx), .data_out(data_out));

   function automatic logic [23:0] to_order(input logic [23:0] p);
      return {p[17:16], p[15:0], p[23:18]};
   endfunction

   function automatic logic [23:0] to_packed(input logic [23:0] o);
      return {o[5:0], o[23:22], o[21:14], o[13:6]};
   endfunction

   // builds an ordered difference that must decode to byte b, bit i
   function automatic logic [23:0] fix_pattern(input logic [8:0] b, input logic [2:0] i);
      logic [11:0] idx;
      logic [23:0] o;
      idx = {b, i};
      o = '0;
      for (int k = 0; k < 12; k++) o[2*k + int'(idx[k])] = 1'b1;
      return o;
   endfunction

   task automatic ref_classify(input logic [23:0] rd, input logic [23:0] cc,
                               output logic [1:0] st, output logic [8:0] ba,
                               output logic [2:0] bi);
      logic [23:0] d;
      int          ones, pairs;
      d = to_order(rd) ^ to_order(cc);
      ones = 0; pairs = 0;
      for (int k = 0; k < 24; k++) ones += int'(d[k]);
      for (int k = 0; k < 12; k++) if (d[2*k] || d[2*k+1]) pairs++;
      ba = '0; bi = '0;
      if (ones == 0) st = 2'b00;
      else if (pairs == 12) begin
         st = 2'b01;
         for (int k = 0; k < 3; k++) bi[k] = d[2*k+1];
         for (int k = 0; k < 9; k++) ba[k] = d[7+2*k];
      end else if (ones == 1) st = 2'b10;
      else st = 2'b11;
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_result(input string req, input logic [1:0] st, input logic [8:0] ba,
                             input logic [2:0] bi, input logic [7:0] dout);
      chk("R2", {req, " valid"}, 32'(valid), 32'd1);
      chk(req, "status", 32'(status), 32'(st));
      chk("R8", {req, " byte_addr"}, 32'(byte_addr), 32'(ba));
      chk("R8", {req, " bit_idx"}, 32'(bit_idx), 32'(bi));
      chk("R9", {req, " data_out"}, 32'(data_out), 32'(dout));
   endtask

   task automatic run_case(input string req, input logic [23:0] rd, input logic [23:0] cc,
                           input logic [7:0] din, input logic [1:0] st, input logic [8:0] ba,
                           input logic [2:0] bi);
      logic [7:0] dout;
      dout = (st == 2'b01) ? (din ^ (8'd1 << bi)) : din;
      @(negedge clk);
      start = 1'b1; ecc_read = rd; ecc_calc = cc; data_in = din;
      @(negedge clk);
      start = 1'b0;
      chk_result(req, st, ba, bi, dout);
   endtask

   initial begin
      logic [23:0] c, o;
      logic [8:0]  b;
      logic [2:0]  i;
      logic [7:0]  din;
      logic [1:0]  st;
      logic [8:0]  ba;
      logic [2:0]  bi;
      void'($urandom(32'd4242));

      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", 32'(valid), 32'd0);
      chk("R1", "status in reset", 32'(status), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "valid after reset", 32'(valid), 32'd0);
      chk("R1", "status after reset", 32'(status), 32'd0);
      chk("R1", "byte_addr after reset", 32'(byte_addr), 32'd0);
      chk("R1", "bit_idx after reset", 32'(bit_idx), 32'd0);
      chk("R1", "data_out after reset", 32'(data_out), 32'd0);

      // R3: identical codes
      for (int n = 0; n < 6; n++) begin
         c = 24'($urandom);
         run_case("R3", c, c, 8'($urandom), 2'b00, 9'd0, 3'd0);
      end

      // R4 R5: directed extremes of the byte and bit indices
      c = 24'($urandom);
      run_case("R5", c ^ to_packed(fix_pattern(9'd0, 3'd0)), c, 8'h00, 2'b01, 9'd0, 3'd0);
      run_case("R5", c ^ to_packed(fix_pattern(9'd511, 3'd7)), c, 8'hFF, 2'b01, 9'd511, 3'd7);
      run_case("R4", c ^ to_packed(fix_pattern(9'h155, 3'd5)), c, 8'h5A, 2'b01, 9'h155, 3'd5);
      run_case("R4", c ^ to_packed(fix_pattern(9'h0AA, 3'd2)), c, 8'hA5, 2'b01, 9'h0AA, 3'd2);
      for (int n = 0; n < 40; n++) begin
         c = 24'($urandom); b = 9'($urandom); i = 3'($urandom);
         run_case("R5", to_packed(fix_pattern(b, i)) ^ c, c, 8'($urandom), 2'b01, b, i);
      end

      // R6: every single input bit position
      for (int k = 0; k < 24; k++) begin
         c = 24'($urandom);
         run_case("R6", c ^ (24'd1 << k), c, 8'($urandom), 2'b10, 9'd0, 3'd0);
      end

      // R7: two flipped bits can never cover all twelve pairs
      for (int n = 0; n < 20; n++) begin
         int a, z;
         a = int'($urandom_range(23, 0));
         z = (a + 1 + int'($urandom_range(22, 0))) % 24;
         c = 24'($urandom);
         run_case("R7", c ^ (24'd1 << a) ^ (24'd1 << z), c, 8'($urandom), 2'b11, 9'd0, 3'd0);
      end
      run_case("R7", 24'hFFFFFF, 24'h000000, 8'h3C, 2'b01, 9'h1FF, 3'd7);

      // random code pairs against the reference classifier
      for (int n = 0; n < 60; n++) begin
         logic [23:0] rd, cc;
         rd = 24'($urandom); cc = 24'($urandom);
         if (n % 3 == 0) cc = rd ^ to_packed(24'($urandom) | 24'h555555);
         ref_classify(rd, cc, st, ba, bi);
         run_case("R7", rd, cc, 8'($urandom), st, ba, bi);
      end

      // R2: outputs hold while start is low
      c = 24'($urandom);
      run_case("R2", c ^ to_packed(fix_pattern(9'd77, 3'd3)), c, 8'h11, 2'b01, 9'd77, 3'd3);
      ecc_read = 24'($urandom); ecc_calc = 24'($urandom); data_in = 8'($urandom);
      @(negedge clk);
      chk("R2", "valid low without start", 32'(valid), 32'd0);
      chk("R2", "status held", 32'(status), 32'd1);
      chk("R2", "byte_addr held", 32'(byte_addr), 32'd77);
      chk("R2", "data_out held", 32'(data_out), 32'h19);

      // R2 R9: strobes on consecutive cycles, each result checked before the next drive
      begin
         logic [1:0] p_st;
         logic [8:0] p_ba;
         logic [2:0] p_bi;
         logic [7:0] p_do;
         for (int n = 0; n < 32; n++) begin
            logic [23:0] rd;
            c = 24'($urandom); din = 8'($urandom);
            case (n % 4)
               0: begin b = 9'($urandom); i = 3'($urandom); rd = c ^ to_packed(fix_pattern(b, i)); end
               1: rd = c ^ (24'd1 << $urandom_range(23, 0));
               2: rd = c;
               default: rd = c ^ 24'h000003;
            endcase
            @(negedge clk);
            if (n > 0) chk_result("R9", p_st, p_ba, p_bi, p_do);
            start = 1'b1; ecc_read = rd; ecc_calc = c; data_in = din;
            ref_classify(rd, c, p_st, p_ba, p_bi);
            p_do = (p_st == 2'b01) ? (din ^ (8'd1 << p_bi)) : din;
         end
         @(negedge clk);
         start = 1'b0;
         chk_result("R9", p_st, p_ba, p_bi, p_do);
         @(negedge clk);
         chk("R2", "valid drops after burst", 32'(valid), 32'd0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule